// File: doc/BRIEF.md
# Programmable Static Operand Router

This block is the per-tile switch of a two-dimensional mesh that carries 32-bit operand words. It links five ports: the tile's own compute pipeline and the four mesh neighbours. Packets carry no headers. A short route program held in a local instruction memory fixes which inputs feed which outputs at each step, and in what order. Each program step pairs a crossbar setting with a control operation: advance, jump, or branch when a word taken from a chosen input is zero. Routers on different tiles can therefore follow the same branch decision when the condition word is sent to each of them.

Each port has its own input queue, which registers arriving words. One program step may send a single queued word to several outputs at once. A step fires only as a whole. It needs a word at every input it reads and room at every output it writes. If either is missing, the step waits and changes nothing. The program is written through a load port while the router is held in reset, and execution starts at address 0 when reset is released.

Top module: `sor_router`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, no `out_valid` bit is set, every input queue is empty, and every `in_ready` bit is high. The program counter starts at address 0.
- R2: A `prog_we` write stores `prog_wdata` at `prog_addr` only while `rst` is high. A write made while `rst` is low leaves the program unchanged.
- R3: Port indices are pipeline=0, north=1, east=2, south=3, west=4. Instruction bits [2:0] hold the opcode, [5:3] the test port, [9:6] the branch target, and bits [12+3k:10+3k] the source code for output port k. A source code of 0 to 4 drives that output from the head of that input queue. Codes 5, 6 and 7 leave the output idle.
- R4: When a step names one source for several outputs, the same word appears on all of them in the same cycle and is removed from its queue only once.
- R5: A step fires only when every input it reads holds a word and every output it drives has `out_ready` high. A step that cannot fire raises no `out_valid` bit, removes no word and keeps the program counter.
- R6: Opcode 2 (branch if zero) removes one word from the test port's queue. If that word is zero the next step is the target; otherwise it is the following address. With no word at the test port, the step waits.
- R7: Opcode 1 (jump) continues at the target address. Opcode 0 and codes 3 to 7 continue at the following address.
- R8: Each input queue holds 4 words. `in_ready` for a port is low while its queue is full, and a word offered then is not taken. Words from one input leave in the order they arrived.
- R9: A word taken at a clock edge is registered first. The earliest it can appear on an output is the cycle that begins at that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high; also enables program loading |
| prog_we | input | 1 | Instruction memory write strobe |
| prog_addr | input | 4 | Instruction memory write address |
| prog_wdata | input | 25 | Instruction word to store |
| in_valid | input | 5 | Per-port word offered |
| in_data | input | 5x32 | Per-port offered word |
| in_ready | output | 5 | Per-port queue has room |
| out_ready | input | 5 | Per-port downstream has room |
| out_valid | output | 5 | Per-port word driven this cycle |
| out_data | output | 5x32 | Per-port driven word |

## Verification
The bench goes after the atomic firing rule. One step reads two inputs and writes three outputs, and the bench starves one input and then blocks one output. A design that fired part of the step would leak a word to an unblocked output, and a design that dequeued anyway would lose words. The bench also fills a queue and offers a fifth word, which an off-by-one full flag would accept or drop. It branches on zero, nonzero and top-bit-only words, where a design that tested only the low bits or forgot to dequeue the test word would send words to the wrong neighbour. It also writes the program while the router runs and checks that a reset brings the old program back.

// File: rtl/sor_pkg.sv
package sor_pkg;
  localparam int NPORT = 5;
  localparam int SEL_W = 3;
  localparam int OP_W  = 3;

  localparam logic [OP_W-1:0] OP_NOP = 3'd0;
  localparam logic [OP_W-1:0] OP_JMP = 3'd1;
  localparam logic [OP_W-1:0] OP_JZ  = 3'd2;

  function automatic int instr_width(input int aw);
    return OP_W + SEL_W + aw + NPORT * SEL_W;
  endfunction

  // a select code names a real port only below NPORT
  function automatic logic sel_is_port(input logic [SEL_W-1:0] s);
    return s < SEL_W'(NPORT);
  endfunction

  function automatic logic word_is_zero(input logic [31:0] w);
    return w == 32'd0;
  endfunction
endpackage

// File: rtl/sor_fifo.sv
module sor_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [W-1:0]     wdata,
  input  logic             pop,
  output logic [W-1:0]     rdata,
  output logic             empty,
  output logic             full,
  output logic [CNT_W-1:0] count
);
  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wp, rp;
  logic             push_ok, pop_ok;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty   = (count == '0);
  assign full    = (count == CNT_W'(DEPTH));
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign rdata   = mem[rp];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wp] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (push_ok) wp <= ptr_inc(wp);
      if (pop_ok)  rp <= ptr_inc(rp);
      case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/sor_imem.sv
module sor_imem #(
  parameter int AW = 4,
  parameter int IW = 25,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [IW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [IW-1:0] rdata
);
  logic [IW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/sor_xbar.sv
module sor_xbar
  import sor_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [NPORT-1:0][W-1:0]     heads,
  input  logic [NPORT-1:0][SEL_W-1:0] route,
  output logic [NPORT-1:0][W-1:0]     out_data
);
  for (genvar o = 0; o < NPORT; o++) begin : g_out
    logic [W-1:0] pick;
    always_comb begin
      pick = '0;
      for (int s = 0; s < NPORT; s++) begin
        if (route[o] == SEL_W'(s)) pick = heads[s];
      end
    end
    assign out_data[o] = pick;
  end
endmodule

// File: rtl/sor_seq.sv
module sor_seq
  import sor_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int PROG_AW = 4
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic [OP_W-1:0]                 op,
  input  logic [SEL_W-1:0]                tport,
  input  logic [PROG_AW-1:0]              target,
  input  logic [NPORT-1:0][SEL_W-1:0]     route,
  input  logic [NPORT-1:0]                src_avail,
  input  logic [NPORT-1:0]                dst_ready,
  input  logic [NPORT-1:0][DATA_W-1:0]    heads,
  output logic                            fire,
  output logic [NPORT-1:0]                deq,
  output logic [NPORT-1:0]                out_act,
  output logic [DATA_W-1:0]               test_word,
  output logic [PROG_AW-1:0]              pc
);
  logic [NPORT-1:0]   need_src;
  logic [NPORT-1:0]   dst_used;
  logic               is_jz;
  logic               take;
  logic [PROG_AW-1:0] pc_next;

  assign is_jz = (op == OP_JZ) && sel_is_port(tport);

  always_comb begin
    need_src  = '0;
    test_word = '1;
    for (int o = 0; o < NPORT; o++) begin
      for (int s = 0; s < NPORT; s++) begin
        if (route[o] == SEL_W'(s)) need_src[s] = 1'b1;
      end
    end
    for (int s = 0; s < NPORT; s++) begin
      if (is_jz && tport == SEL_W'(s)) begin
        need_src[s] = 1'b1;
        test_word   = heads[s];
      end
    end
  end

  for (genvar o = 0; o < NPORT; o++) begin : g_dst
    assign dst_used[o] = sel_is_port(route[o]);
  end

  assign fire    = !rst && ((need_src & ~src_avail) == '0)
                        && ((dst_used & ~dst_ready) == '0);
  assign deq     = need_src & {NPORT{fire}};
  assign out_act = dst_used & {NPORT{fire}};
  assign take    = is_jz && word_is_zero(test_word);

  always_comb begin
    case (op)
      OP_JMP:  pc_next = target;
      OP_JZ:   pc_next = take ? target : pc + 1'b1;
      default: pc_next = pc + 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)       pc <= '0;
    else if (fire) pc <= pc_next;
  end
endmodule

// File: rtl/sor_router.sv
module sor_router
  import sor_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int PROG_AW    = 4,
  parameter int FIFO_DEPTH = 4,
  localparam int INSTR_W   = instr_width(PROG_AW),
  localparam int CNT_W     = $clog2(FIFO_DEPTH + 1),
  localparam int TGT_LO    = OP_W + SEL_W,
  localparam int ROUTE_LO  = TGT_LO + PROG_AW
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         prog_we,
  input  logic [PROG_AW-1:0]           prog_addr,
  input  logic [INSTR_W-1:0]           prog_wdata,
  input  logic [NPORT-1:0]             in_valid,
  input  logic [NPORT-1:0][DATA_W-1:0] in_data,
  output logic [NPORT-1:0]             in_ready,
  input  logic [NPORT-1:0]             out_ready,
  output logic [NPORT-1:0]             out_valid,
  output logic [NPORT-1:0][DATA_W-1:0] out_data
);
  // named internal events, observed by the bound checker
  logic [INSTR_W-1:0]              instr;
  logic [OP_W-1:0]                 cur_op;
  logic [SEL_W-1:0]                cur_tport;
  logic [PROG_AW-1:0]              cur_target;
  logic [NPORT-1:0][SEL_W-1:0]     route;
  logic [PROG_AW-1:0]              pc;
  logic                            fire;
  logic [NPORT-1:0]                deq;
  logic [NPORT-1:0]                push;
  logic [NPORT-1:0]                empty;
  logic [NPORT-1:0]                full;
  logic [NPORT-1:0][CNT_W-1:0]     fifo_cnt;
  logic [NPORT-1:0][DATA_W-1:0]    heads;
  logic [DATA_W-1:0]               test_word;
  logic                            load_en;

  assign load_en = prog_we && rst;

  sor_imem #(.AW(PROG_AW), .IW(INSTR_W)) i_imem (
    .clk   (clk),
    .we    (load_en),
    .waddr (prog_addr),
    .wdata (prog_wdata),
    .raddr (pc),
    .rdata (instr)
  );

  assign cur_op     = instr[OP_W-1:0];
  assign cur_tport  = instr[OP_W +: SEL_W];
  assign cur_target = instr[TGT_LO +: PROG_AW];

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    assign route[p]    = instr[ROUTE_LO + SEL_W*p +: SEL_W];
    assign push[p]     = in_valid[p] && !full[p];
    assign in_ready[p] = !full[p];

    sor_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) i_fifo (
      .clk   (clk),
      .rst   (rst),
      .push  (push[p]),
      .wdata (in_data[p]),
      .pop   (deq[p]),
      .rdata (heads[p]),
      .empty (empty[p]),
      .full  (full[p]),
      .count (fifo_cnt[p])
    );
  end

  sor_seq #(.DATA_W(DATA_W), .PROG_AW(PROG_AW)) i_seq (
    .clk       (clk),
    .rst       (rst),
    .op        (cur_op),
    .tport     (cur_tport),
    .target    (cur_target),
    .route     (route),
    .src_avail (~empty),
    .dst_ready (out_ready),
    .heads     (heads),
    .fire      (fire),
    .deq       (deq),
    .out_act   (out_valid),
    .test_word (test_word),
    .pc        (pc)
  );

  sor_xbar #(.W(DATA_W)) i_xbar (
    .heads    (heads),
    .route    (route),
    .out_data (out_data)
  );
endmodule

// File: rtl/sor_router_chk.sv
module sor_router_chk
  import sor_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int PROG_AW    = 4,
  parameter int FIFO_DEPTH = 4,
  parameter int CNT_W      = 3
) (
  input logic                     clk,
  input logic                     rst,
  input logic [NPORT-1:0]         in_ready,
  input logic [NPORT-1:0]         out_valid,
  input logic [NPORT-1:0]         out_ready,
  input logic                     fire,
  input logic [PROG_AW-1:0]       pc,
  input logic [NPORT-1:0]         deq,
  input logic [NPORT-1:0]         push,
  input logic [NPORT-1:0][CNT_W-1:0] fifo_cnt,
  input logic [OP_W-1:0]          cur_op,
  input logic [PROG_AW-1:0]       cur_target,
  input logic [DATA_W-1:0]        test_word
);
  AST_PC_RESET: assert property (@(posedge clk) rst |=> pc == '0); // R1

  AST_STALL_PC_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !fire |=> pc == $past(pc)); // R5

  AST_JMP_TARGET: assert property (@(posedge clk) disable iff (rst)
    (fire && cur_op == OP_JMP) |=> pc == $past(cur_target)); // R7

  AST_JZ_TAKEN: assert property (@(posedge clk) disable iff (rst)
    (fire && cur_op == OP_JZ && test_word == '0) |=> pc == $past(cur_target)); // R6

  AST_JZ_FALLTHRU: assert property (@(posedge clk) disable iff (rst)
    (fire && cur_op == OP_JZ && test_word != '0) |=> pc == $past(pc) + 1'b1); // R6

  for (genvar p = 0; p < NPORT; p++) begin : g_chk
    AST_OUT_NEEDS_READY: assert property (@(posedge clk) disable iff (rst)
      out_valid[p] |-> (out_ready[p] && fire)); // R5

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
      fifo_cnt[p] <= CNT_W'(FIFO_DEPTH)); // R8

    AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (rst)
      (fifo_cnt[p] == CNT_W'(FIFO_DEPTH)) |-> !in_ready[p]); // R8

    AST_POP_ONCE: assert property (@(posedge clk) disable iff (rst)
      (deq[p] && !push[p]) |=> fifo_cnt[p] == $past(fifo_cnt[p]) - 1'b1); // R4
  end
endmodule

bind sor_router sor_router_chk #(
  .DATA_W     (DATA_W),
  .PROG_AW    (PROG_AW),
  .FIFO_DEPTH (FIFO_DEPTH),
  .CNT_W      (CNT_W)
) i_chk (
  .clk        (clk),
  .rst        (rst),
  .in_ready   (in_ready),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .fire       (fire),
  .pc         (pc),
  .deq        (deq),
  .push       (push),
  .fifo_cnt   (fifo_cnt),
  .cur_op     (cur_op),
  .cur_target (cur_target),
  .test_word  (test_word)
);

// File: tb/test_sor_router.sv
module test_sor_router;
  localparam int CLK_PERIOD = 10;
  localparam int PP = 0, PN = 1, PE = 2, PS = 3, PW = 4;
  localparam logic [2:0] IDL = 3'd7;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              prog_we = 1'b0;
  logic [3:0]        prog_addr = '0;
  logic [24:0]       prog_wdata = '0;
  logic [4:0]        in_valid = '0;
  logic [4:0][31:0]  in_data = '0;
  logic [4:0]        in_ready;
  logic [4:0]        out_ready = '1;
  logic [4:0]        out_valid;
  logic [4:0][31:0]  out_data;

  int checks = 0;
  int errors = 0;
  logic [31:0] expq [5][$];
  logic [24:0] prog [16];

  always #(CLK_PERIOD/2) clk = ~clk;

  sor_router i_sor_router (
    .clk(clk), .rst(rst), .prog_we(prog_we), .prog_addr(prog_addr),
    .prog_wdata(prog_wdata), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .out_ready(out_ready), .out_valid(out_valid),
    .out_data(out_data)
  );

  // instruction layout from R3
  function automatic logic [24:0] mk(input logic [2:0] op, input logic [2:0] tp,
                                     input logic [3:0] tgt, input logic [2:0] rp,
                                     input logic [2:0] rn, input logic [2:0] re,
                                     input logic [2:0] rs, input logic [2:0] rw);
    return {rw, rs, re, rn, rp, tgt, tp, op};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  // scoreboard monitor: every driven word must be the next expected one
  always @(negedge clk) begin
    if (!rst) begin
      for (int p = 0; p < 5; p++) begin
        if (out_valid[p]) begin
          checks++;
          if (expq[p].size() == 0) begin
            errors++;
            $display("FAIL R3 R5 port %0d actual %h expected none", p, out_data[p]);
          end else begin
            logic [31:0] e;
            e = expq[p].pop_front();
            if (out_data[p] !== e) begin
              errors++;
              $display("FAIL R4 R8 port %0d actual %h expected %h", p, out_data[p], e);
            end
          end
        end
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic send(input int p, input logic [31:0] w);
    in_valid[p] = 1'b1;
    in_data[p]  = w;
    forever begin
      @(negedge clk);
      if (in_ready[p]) break;
    end
    @(posedge clk);
    #1 in_valid[p] = 1'b0;
  endtask

  task automatic load();
    rst = 1'b1;
    for (int i = 0; i < 16; i++) begin
      prog_we = 1'b1; prog_addr = 4'(i); prog_wdata = prog[i];
      @(posedge clk); #1;
    end
    prog_we = 1'b0;
    @(negedge clk);
    chk(out_valid == 5'b0, "R1 out_valid in reset", 32'(out_valid), 0);
    chk(in_ready == 5'h1f, "R1 in_ready in reset", 32'(in_ready), 32'h1f);
    @(posedge clk); #1;
    rst = 1'b0;
    @(negedge clk);
    chk(out_valid == 5'b0, "R1 out_valid after reset", 32'(out_valid), 0);
    @(posedge clk); #1;
  endtask

  task automatic drained(input string req);
    for (int p = 0; p < 5; p++)
      chk(expq[p].size() == 0, req, 32'(expq[p].size()), 0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual running expected done");
    summary();
    $finish;
  end

  initial begin
    // ---- program A: E,S <- P (multicast), W <- N, jump to 0
    for (int i = 0; i < 16; i++) prog[i] = mk(3'd0, 3'd0, 4'd0, IDL, IDL, IDL, IDL, IDL);
    prog[0] = mk(3'd1, 3'd0, 4'd0, IDL, IDL, 3'(PP), 3'(PP), 3'(PN));
    #1 load();

    // R9: registered entry, visible in the cycle after acceptance
    expq[PE].push_back(32'h1111_0001); expq[PS].push_back(32'h1111_0001);
    expq[PW].push_back(32'h0000_00a0);
    send(PN, 32'h0000_00a0);
    in_valid[PP] = 1'b1; in_data[PP] = 32'h1111_0001;
    @(negedge clk);
    chk(out_valid[PE] == 1'b0, "R9 not before registered", 32'(out_valid[PE]), 0);
    @(posedge clk); #1 in_valid[PP] = 1'b0;
    @(negedge clk);
    chk(out_valid[PE] && out_data[PE] == 32'h1111_0001, "R9 visible after entry",
        out_data[PE], 32'h1111_0001);
    chk(out_valid[PS] && out_data[PS] == 32'h1111_0001, "R4 multicast same cycle",
        out_data[PS], 32'h1111_0001);
    @(posedge clk); #1;

    // R3 R4: several multicast pairs
    for (int k = 0; k < 4; k++) begin
      expq[PE].push_back(32'h2222_0000 + 32'(k)); expq[PS].push_back(32'h2222_0000 + 32'(k));
      expq[PW].push_back(32'h3333_0000 + 32'(k));
      send(PN, 32'h3333_0000 + 32'(k));
      send(PP, 32'h2222_0000 + 32'(k));
    end
    idle(4);
    drained("R4 multicast words delivered once");

    // R5: source starvation (N missing) holds the whole step
    expq[PE].push_back(32'h4444_0001); expq[PS].push_back(32'h4444_0001);
    expq[PW].push_back(32'h5555_0001);
    send(PP, 32'h4444_0001);
    idle(6);
    chk(expq[PE].size() == 1, "R5 no partial fire on empty source", 32'(expq[PE].size()), 1);
    send(PN, 32'h5555_0001);
    idle(4);
    drained("R5 step fires once source arrives");

    // R5 R8: blocked destination, full queue, rejected fifth word
    out_ready[PS] = 1'b0;
    for (int k = 0; k < 4; k++) begin
      expq[PE].push_back(32'h6666_0000 + 32'(k)); expq[PS].push_back(32'h6666_0000 + 32'(k));
      expq[PW].push_back(32'h7777_0000 + 32'(k));
      send(PP, 32'h6666_0000 + 32'(k));
      send(PN, 32'h7777_0000 + 32'(k));
    end
    idle(3);
    chk(expq[PE].size() == 4, "R5 blocked output stalls all outputs", 32'(expq[PE].size()), 4);
    @(negedge clk);
    chk(in_ready[PP] == 1'b0, "R8 in_ready low when 4 held", 32'(in_ready[PP]), 0);
    @(posedge clk); #1;
    in_valid[PP] = 1'b1; in_data[PP] = 32'hdead_beef;
    idle(3);
    in_valid[PP] = 1'b0;
    out_ready[PS] = 1'b1;
    idle(8);
    drained("R8 four words in order, fifth refused");

    // ---- program B: branch on N word
    prog[0] = mk(3'd2, 3'(PN), 4'd2, IDL, IDL, IDL, IDL, IDL);
    prog[1] = mk(3'd1, 3'd0, 4'd0, IDL, 3'd6, 3'(PW), IDL, IDL);
    prog[2] = mk(3'd1, 3'd0, 4'd0, IDL, IDL, IDL, 3'(PW), 3'd5);
    load();
    send(PW, 32'h0000_0b01);
    idle(5);
    @(negedge clk);
    chk(out_valid == 5'b0, "R6 branch waits for test word", 32'(out_valid), 0);
    @(posedge clk); #1;
    expq[PS].push_back(32'h0000_0b01);
    send(PN, 32'h0);
    idle(4);
    drained("R6 zero word takes branch");
    expq[PE].push_back(32'h0000_0b02);
    send(PN, 32'h0000_0005);
    send(PW, 32'h0000_0b02);
    idle(4);
    drained("R6 nonzero word falls through");
    expq[PE].push_back(32'h0000_0b03);
    expq[PS].push_back(32'h0000_0b04);
    send(PN, 32'h8000_0000);
    send(PW, 32'h0000_0b03);
    send(PN, 32'h0);
    send(PW, 32'h0000_0b04);
    idle(6);
    drained("R6 top bit counts as nonzero");

    // ---- program C: NOP advance and jump over addresses 3 and 4
    for (int i = 0; i < 16; i++) prog[i] = mk(3'd0, 3'd0, 4'd0, IDL, IDL, IDL, IDL, IDL);
    prog[0] = mk(3'd0, 3'd0, 4'd0, IDL, IDL, 3'(PP), IDL, IDL);
    prog[1] = mk(3'd5, 3'd0, 4'd9, IDL, IDL, IDL, 3'(PP), IDL);
    prog[2] = mk(3'd1, 3'd0, 4'd5, IDL, 3'(PP), IDL, IDL, IDL);
    prog[3] = mk(3'd0, 3'd0, 4'd0, IDL, IDL, IDL, IDL, 3'(PP));
    prog[4] = mk(3'd0, 3'd0, 4'd0, IDL, IDL, IDL, IDL, 3'(PP));
    prog[5] = mk(3'd1, 3'd0, 4'd0, 3'(PP), IDL, IDL, IDL, IDL);
    load();
    for (int k = 0; k < 8; k++) begin
      int dst;
      dst = (k % 4 == 0) ? PE : (k % 4 == 1) ? PS : (k % 4 == 2) ? PN : PP;
      expq[dst].push_back(32'hc000_0000 + 32'(k));
    end
    for (int k = 0; k < 8; k++) send(PP, 32'hc000_0000 + 32'(k));
    idle(6);
    drained("R7 jump and advance order");

    // ---- R2: write while running is ignored, reset restores old program
    prog_we = 1'b1; prog_addr = 4'd0;
    prog_wdata = mk(3'd0, 3'd0, 4'd0, IDL, IDL, IDL, IDL, 3'(PP));
    idle(1);
    prog_we = 1'b0;
    rst = 1'b1;
    idle(2);
    rst = 1'b0;
    idle(1);
    expq[PE].push_back(32'hd000_0001);
    send(PP, 32'hd000_0001);
    idle(4);
    drained("R2 run-time write ignored");

    summary();
    $finish;
  end
endmodule